// File: doc/BRIEF.md
# I/O Trap Wait-State Handshake

This block lets a helper controller serve a group of CPU I/O ports in firmware. It watches the CPU I/O strobe. When an I/O cycle opens on one of sixteen ports whose low address byte has upper nibble 8 (ports 0x80..0x8F), it arms a trap. While the trap is armed, the block holds the CPU WAIT line low. It also raises an active-low flag toward the helper.

The helper receives the following while the trap is armed:
- the transfer direction;
- the upper address byte and the low address nibble, captured when the trap arms, which it decodes as a command.

When the helper has finished, it pulls its clear line low. The block then drops the trap and releases WAIT. The helper keeps clear low until the I/O strobe has gone inactive. If the access needs bus mastering, the helper requests the bus before it clears. It then watches a synchronized copy of the bus-grant line to learn when the CPU has parked.

The whole block runs in the CPU clock domain. I/O cycles arm the trap only on the falling edge of the sampled strobe, so an I/O cycle that is still open never arms the trap a second time. Interrupt-acknowledge cycles (strobe and M1 both low) are ignored. The clear line and the bus-grant line each pass through a two-flop synchronizer.

Top module: `io_trap_stall`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cpu_wait_n` and `cop_trap_n` are 1 and `cop_bus_held` is 0.
- R2: A clock edge that samples `cpu_iorq_n` low, after it was high at the previous edge, arms the trap at that edge when all three hold: `cpu_m1_n` is high, `cpu_addr[7:4]` equals 4'h8, and the synchronized clear is inactive. From that edge on, `cpu_wait_n` and `cop_trap_n` both read 0.
- R3: Accesses with `cpu_addr[7:4]` other than 4'h8 never arm the trap. `cpu_addr[15:8]` and `cpu_addr[3:0]` have no effect on the match.
- R4: An I/O cycle with `cpu_m1_n` low (interrupt acknowledge) does not arm the trap.
- R5: Clear wins over arming. While the synchronized clear is active, a matching I/O edge leaves the trap disarmed.
- R6: After `cop_clr_n` goes low, the trap stays armed through the second clock edge. It is released at the third edge, and `cpu_wait_n` then returns to 1.
- R7: An I/O cycle that stays open after the trap was cleared does not re-arm the trap, even if `cop_clr_n` returns high first.
- R8: While the trap is armed, `cop_is_read` equals NOT `cpu_rd_n` and `cop_is_write` equals NOT `cpu_wr_n`. Both are 0 while the trap is disarmed.
- R9: `cop_page` holds `cpu_addr[15:8]` and `cop_port` holds `cpu_addr[3:0]`, as captured at the edge that armed the trap. Both stay stable while the trap is armed, even if the address changes.
- R10: `cop_bus_held` rises at the second clock edge after `cpu_busack_n` is first sampled low. It falls the same way after `cpu_busack_n` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_iorq_n | input | 1 | CPU I/O request, active low |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_m1_n | input | 1 | CPU opcode-fetch / acknowledge marker, active low |
| cpu_busack_n | input | 1 | CPU bus grant, active low |
| cpu_wait_n | output | 1 | Stall request to the CPU, active low |
| cop_clr_n | input | 1 | Helper clear request, active low |
| cop_trap_n | output | 1 | Trap armed flag, active low |
| cop_is_read | output | 1 | Trapped access is an input operation |
| cop_is_write | output | 1 | Trapped access is an output operation |
| cop_page | output | 8 | Captured upper address byte |
| cop_port | output | 4 | Captured low address nibble |
| cop_bus_held | output | 1 | Synchronized bus-grant indication |

## Verification
A trap state that is stuck or lost shows up at once on `cpu_wait_n` and `cop_trap_n`, one edge after the I/O strobe falls. A clear path that is too short or too long moves the release of `cpu_wait_n` off the third edge after clear. An arming condition that is level-sensitive instead of edge-sensitive re-arms the trap one edge after clear is dropped while the strobe is still low. A capture enable that fires at the wrong time changes `cop_page` or `cop_port` within a cycle of the address moving.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;
  parameter int unsigned BUS_AW = 16;
  parameter int unsigned SEL_LO = 4;
  parameter int unsigned SEL_HI = 7;
  localparam int unsigned SEL_W  = SEL_HI - SEL_LO + 1;
  localparam int unsigned PAGE_W = BUS_AW - SEL_HI - 1;
  localparam int unsigned PORT_W = SEL_LO;

  typedef enum logic {
    TRAP_IDLE = 1'b0,
    TRAP_HELD = 1'b1
  } trap_state_e;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [PORT_W-1:0] port;
  } trap_cmd_t;
endpackage

// File: rtl/io_trap_sync.sv
module io_trap_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= RESET_VAL;
        else        stage_q <= d;
      end
      assign q = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb chain_d = {chain_q[STAGES-2:0], d};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/io_trap_decode.sv
module io_trap_decode
  import io_trap_pkg::*;
#(
  parameter logic [SEL_W-1:0] WIN_MATCH = 4'h8
) (
  input  logic [BUS_AW-1:0] addr,
  output logic              hit,
  output trap_cmd_t         cmd
);
  always_comb begin
    hit      = (addr[SEL_HI:SEL_LO] == WIN_MATCH);
    cmd.page = addr[BUS_AW-1:SEL_HI+1];
    cmd.port = addr[SEL_LO-1:0];
  end
endmodule

// File: rtl/io_trap_core.sv
module io_trap_core
  import io_trap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      iorq_n,
  input  logic      m1_n,
  input  logic      hit,
  input  logic      clr_act,
  input  trap_cmd_t cmd_in,
  output logic      armed,
  output trap_cmd_t cmd_q
);
  trap_state_e state_q, state_d;
  logic        iorq_prev_q;
  logic        set_req;
  logic        cap_en;

  always_comb begin
    set_req = iorq_prev_q && !iorq_n && m1_n && hit;
    state_d = state_q;
    if (clr_act)      state_d = TRAP_IDLE;
    else if (set_req) state_d = TRAP_HELD;
    cap_en = (state_d == TRAP_HELD) && (state_q == TRAP_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= TRAP_IDLE;
      iorq_prev_q <= 1'b1;
    end else begin
      state_q     <= state_d;
      iorq_prev_q <= iorq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cap_en) cmd_q <= cmd_in;
  end

  assign armed = (state_q == TRAP_HELD);
endmodule

// File: rtl/io_trap_stall.sv
module io_trap_stall
  import io_trap_pkg::*;
#(
  parameter logic [SEL_W-1:0] WIN_MATCH   = 4'h8,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] cpu_addr,
  input  logic              cpu_iorq_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic              cpu_m1_n,
  input  logic              cpu_busack_n,
  output logic              cpu_wait_n,
  input  logic              cop_clr_n,
  output logic              cop_trap_n,
  output logic              cop_is_read,
  output logic              cop_is_write,
  output logic [PAGE_W-1:0] cop_page,
  output logic [PORT_W-1:0] cop_port,
  output logic              cop_bus_held
);
  logic      clr_n_s;
  logic      busack_n_s;
  logic      hit;
  logic      armed;
  trap_cmd_t cmd_now;
  trap_cmd_t cmd_q;

  io_trap_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) clr_sync_i (
    .clk(clk), .rst_n(rst_n), .d(cop_clr_n), .q(clr_n_s)
  );

  io_trap_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) ack_sync_i (
    .clk(clk), .rst_n(rst_n), .d(cpu_busack_n), .q(busack_n_s)
  );

  io_trap_decode #(.WIN_MATCH(WIN_MATCH)) decode_i (
    .addr(cpu_addr), .hit(hit), .cmd(cmd_now)
  );

  io_trap_core core_i (
    .clk(clk), .rst_n(rst_n), .iorq_n(cpu_iorq_n), .m1_n(cpu_m1_n),
    .hit(hit), .clr_act(!clr_n_s), .cmd_in(cmd_now),
    .armed(armed), .cmd_q(cmd_q)
  );

  always_comb begin
    cpu_wait_n   = !armed;
    cop_trap_n   = !armed;
    cop_is_read  = armed && !cpu_rd_n;
    cop_is_write = armed && !cpu_wr_n;
    cop_page     = cmd_q.page;
    cop_port     = cmd_q.port;
    cop_bus_held = !busack_n_s;
  end
endmodule

// File: rtl/io_trap_stall_chk.sv
module io_trap_stall_chk
  import io_trap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] cpu_addr,
  input logic              cpu_iorq_n,
  input logic              cpu_rd_n,
  input logic              cpu_wr_n,
  input logic              cpu_m1_n,
  input logic              cpu_busack_n,
  input logic              cpu_wait_n,
  input logic              cop_clr_n,
  input logic              cop_trap_n,
  input logic              cop_is_read,
  input logic              cop_is_write,
  input logic [PAGE_W-1:0] cop_page,
  input logic [PORT_W-1:0] cop_port,
  input logic              cop_bus_held
);
  assert_arm_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_iorq_n) && cpu_m1_n && cpu_addr[SEL_HI:SEL_LO] == 4'h8 &&
     cop_clr_n && $past(cop_clr_n) && $past(cop_clr_n, 2))
    |=> !cop_trap_n);

  assert_no_arm_off_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_trap_n && (cpu_addr[SEL_HI:SEL_LO] != 4'h8 || !cpu_m1_n)) |=> cop_trap_n);

  assert_clear_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cop_clr_n) && $past(!cop_clr_n, 2) && $past(!cop_clr_n, 3))
    |-> (cop_trap_n && cpu_wait_n));

  assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_iorq_n && $past(!cpu_iorq_n) && cop_trap_n) |=> cop_trap_n);

  assert_cmd_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cop_trap_n && $past(!cop_trap_n)) |-> $stable({cop_page, cop_port}));

  assert_dir_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cop_trap_n |-> !(cop_is_read || cop_is_write));

  assert_busack_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cpu_busack_n) && $past(!cpu_busack_n, 2)) |-> cop_bus_held);
endmodule

bind io_trap_stall io_trap_stall_chk chk_i (.*);

// File: tb/io_trap_stall_tb_top.sv
`timescale 1ns/1ps
module io_trap_stall_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_iorq_n, cpu_rd_n, cpu_wr_n, cpu_m1_n, cpu_busack_n;
  logic        cpu_wait_n, cop_clr_n, cop_trap_n, cop_is_read, cop_is_write;
  logic [7:0]  cop_page;
  logic [3:0]  cop_port;
  logic        cop_bus_held;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  typedef struct {
    int          due;
    logic [16:0] mask;
    logic [16:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  localparam logic [16:0] M_WAIT = 17'h10000;
  localparam logic [16:0] M_TRAP = 17'h08000;
  localparam logic [16:0] M_RD   = 17'h04000;
  localparam logic [16:0] M_WR   = 17'h02000;
  localparam logic [16:0] M_HELD = 17'h01000;
  localparam logic [16:0] M_CMD  = 17'h00FFF;

  io_trap_stall dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_iorq_n(cpu_iorq_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_m1_n(cpu_m1_n),
    .cpu_busack_n(cpu_busack_n), .cpu_wait_n(cpu_wait_n), .cop_clr_n(cop_clr_n),
    .cop_trap_n(cop_trap_n), .cop_is_read(cop_is_read), .cop_is_write(cop_is_write),
    .cop_page(cop_page), .cop_port(cop_port), .cop_bus_held(cop_bus_held)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // monitor: pops expected items as their cycle comes due
  initial forever begin
    @(negedge clk);
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      logic [16:0] obs;
      it  = sb_q.pop_front();
      obs = {cpu_wait_n, cop_trap_n, cop_is_read, cop_is_write, cop_bus_held,
             cop_page, cop_port};
      tests++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        fails++;
        $display("FAIL %s: actual %05h expected %05h (mask %05h) at cycle %0d",
                 it.req, obs & it.mask, it.exp & it.mask, it.mask, cyc);
      end
    end
  end

  task automatic push(input int delta, input logic [16:0] m,
                      input logic [16:0] e, input string r);
    item_t it;
    it.due = cyc + delta; it.mask = m; it.exp = e; it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_idle();
    cpu_addr = 16'h0000; cpu_iorq_n = 1'b1; cpu_rd_n = 1'b1;
    cpu_wr_n = 1'b1; cpu_m1_n = 1'b1;
  endtask

  // expectation that the trap is not armed one edge later
  task automatic try_no_trap(input logic [15:0] a, input logic m1, input string r);
    cpu_addr = a; cpu_m1_n = m1; cpu_iorq_n = 1'b0; cpu_rd_n = m1 ? 1'b0 : 1'b1;
    push(1, M_WAIT | M_TRAP, {1'b1, 1'b1, 15'h0}, r);
    push(2, M_WAIT | M_TRAP, {1'b1, 1'b1, 15'h0}, r);
    tick(2);
    bus_idle();
    tick(2);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cop_clr_n = 1'b1; cpu_busack_n = 1'b1;
    bus_idle();
    tick(4);
    rst_n = 1'b1;
    // R1: idle after reset
    push(1, M_WAIT | M_TRAP | M_HELD | M_RD | M_WR, {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h0}, "R1");
    tick(3);

    // R2/R8/R9: input operation on port 0x80 with page 0x34
    cpu_addr = 16'h3480; cpu_iorq_n = 1'b0; cpu_rd_n = 1'b0;
    push(1, M_WAIT | M_TRAP | M_RD | M_WR | M_CMD,
         {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h34, 4'h0}, "R2 R8 R9 port 0x80 read");
    tick(1);
    cpu_addr = 16'hA5C3;
    push(1, M_TRAP | M_CMD, {1'b0, 1'b0, 3'b000, 8'h34, 4'h0}, "R9 capture held");
    tick(1);
    cop_clr_n = 1'b0;
    push(2, M_WAIT | M_TRAP, {1'b0, 1'b0, 15'h0}, "R6 still armed at edge 2");
    push(3, M_WAIT | M_TRAP | M_RD, {1'b1, 1'b1, 1'b0, 14'h0}, "R6 released at edge 3");
    tick(4);
    bus_idle();
    tick(1);
    cop_clr_n = 1'b1;
    tick(3);

    // R2/R8/R7: output operation on port 0x8F, clear dropped while IORQ still low
    cpu_addr = 16'h008F; cpu_iorq_n = 1'b0; cpu_wr_n = 1'b0;
    push(1, M_WAIT | M_TRAP | M_RD | M_WR | M_CMD,
         {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'hF}, "R2 R8 port 0x8F write");
    tick(1);
    cop_clr_n = 1'b0;
    push(3, M_TRAP, {1'b0, 1'b1, 15'h0}, "R6 write released");
    tick(4);
    cop_clr_n = 1'b1;
    for (int k = 1; k <= 4; k++) push(k, M_WAIT | M_TRAP, {1'b1, 1'b1, 15'h0}, "R7 no retrigger");
    tick(5);
    bus_idle();
    tick(2);

    // R3: outside the window, upper byte irrelevant
    try_no_trap(16'h007F, 1'b1, "R3 port 0x7F");
    try_no_trap(16'h0090, 1'b1, "R3 port 0x90");
    try_no_trap(16'h80F8, 1'b1, "R3 page 0x80 port 0xF8");
    // R3: upper byte does not block a match
    cpu_addr = 16'hFF85; cpu_iorq_n = 1'b0; cpu_rd_n = 1'b0;
    push(1, M_TRAP | M_CMD, {1'b0, 1'b0, 3'b000, 8'hFF, 4'h5}, "R3 page 0xFF port 0x85 matches");
    tick(1);
    cop_clr_n = 1'b0;
    tick(4);
    bus_idle();
    tick(1);
    cop_clr_n = 1'b1;
    tick(3);

    // R4: interrupt acknowledge
    try_no_trap(16'h0080, 1'b0, "R4 acknowledge ignored");

    // R5: clear held blocks arming
    cop_clr_n = 1'b0;
    tick(3);
    try_no_trap(16'h0085, 1'b1, "R5 clear priority");
    cop_clr_n = 1'b1;
    tick(3);

    // R10: bus grant synchronization
    cpu_busack_n = 1'b0;
    push(1, M_HELD, 17'h0, "R10 not yet held");
    push(2, M_HELD, M_HELD, "R10 held at edge 2");
    tick(4);
    cpu_busack_n = 1'b1;
    push(1, M_HELD, M_HELD, "R10 still held");
    push(2, M_HELD, 17'h0, "R10 dropped at edge 2");
    tick(4);

    if (sb_q.size() != 0) begin
      fails += sb_q.size();
      tests += sb_q.size();
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule